// File: doc/BRIEF.md
# Audio Master Clock Generator

This block turns a system clock running at a fixed multiple of the audio sample rate into the two clocks a serial audio link needs: a bit clock and a left/right frame clock. A 2-bit mode code picks either external-clock operation or one of three master ratios (256, 384 or 512 times the sample rate). In master mode the block drives both clocks, with 64 bit-clock periods in every frame. In external-clock mode it drives neither clock and raises a flag so that neighbouring logic knows the clocks come from outside.

Alongside the serial clocks the block emits single-cycle enable strobes in the system-clock domain. These run at 128 and 64 times the sample rate and pace the decimation filter and modulator logic. A further strobe marks the cycle just before each bit-clock falling edge, which lets a data formatter launch its next bit on the same system-clock edge that lowers the bit clock. The mode code is captured only while the synchronous reset is held, so changing the ratio requires a reset.

Top module: `audio_clk_master`

## Requirements
- R1: The mode code captured during reset selects the operation: 2'b00 is external-clock mode, 2'b01 is master at 512 fs (bit period 8 system clocks), 2'b10 is master at 384 fs (bit period 6), 2'b11 is master at 256 fs (bit period 4). In master mode both output enables are high and the external flag is low.
- R2: In master mode, counting k system-clock edges since reset release, the bit clock is high exactly when (k mod P) is at least P/2, where P is the bit period; it is therefore low in the reset state.
- R3: The frame clock equals 1 exactly when ((k div P) mod 64) is 32 or more, so it is low for the left half (the first 32 bit periods), and it changes only on the edge at which the bit clock falls.
- R4: The 128 fs enable is high for one cycle when (k mod P) equals P/2-1 or P-1, giving one pulse every P/2 system clocks.
- R5: The 64 fs enable is high for one cycle when (k mod P) equals P-1, once per bit period, and always coincides with a 128 fs pulse.
- R6: The falling-edge strobe is high exactly in the cycle before the edge at which the bit clock falls, i.e. when (k mod P) equals P-1.
- R7: In external-clock mode both output enables are low, both clock outputs and all three strobes stay low, and the external flag is high.
- R8: A change of the mode code while reset is low has no effect: the clocks and strobes keep the period of the mode captured at reset.
- R9: A synchronous reset at any point restarts the divider and bit counter from zero, so the pattern after release matches k = 0 regardless of the state before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at 256, 384 or 512 times the sample rate |
| rst | input | 1 | Synchronous reset, active high; mode code is sampled while high |
| modeSel | input | 2 | Mode code (see R1) |
| bitClk | output | 1 | Serial bit clock, 64 periods per frame |
| bitClkOe | output | 1 | Output enable for the bit clock pad, high in master mode |
| frameClk | output | 1 | Left/right frame clock, low for the left channel |
| frameClkOe | output | 1 | Output enable for the frame clock pad, high in master mode |
| extClk | output | 1 | High when external clocks are in use |
| en128 | output | 1 | One-cycle strobe at 128 times the sample rate |
| en64 | output | 1 | One-cycle strobe at 64 times the sample rate |
| bitFallStb | output | 1 | High in the cycle before each bit-clock falling edge |

## Verification
The bench walks each master ratio across more than two full frames against a cycle counter, so a divider that wraps one count early or late, a 384 fs case that splits its six counts unevenly, or a frame clock that flips on the rising bit-clock edge or after 31 or 33 bits shows up as a mismatch at a specific cycle. It switches the mode code mid-run without reset, which catches a design that reads the code live and suddenly stretches its period. Back-to-back resets taken mid-frame catch counters that are not cleared, and the external-clock run catches a design that still drives a pad enable or leaks enable strobes.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

  typedef enum logic [1:0] {
    MODE_EXT  = 2'b00,
    MODE_M512 = 2'b01,
    MODE_M384 = 2'b10,
    MODE_M256 = 2'b11
  } clkMode_e;

  localparam int RATIO_HI  = 512;
  localparam int RATIO_MID = 384;
  localparam int RATIO_LO  = 256;

  typedef struct packed {
    logic active;   // master mode captured
    logic halfHit;  // last count of the low half
    logic wrap;     // last count of the bit period
  } divStb_t;

endpackage

// File: rtl/aud_clk_ctrl.sv
module aud_clk_ctrl
  import aud_clk_pkg::*;
#(
  parameter int BITS_PER_FRAME = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  output divStb_t     stb
);

  localparam int MAX_PERIOD = RATIO_HI / BITS_PER_FRAME;
  localparam int CNT_W      = $clog2(MAX_PERIOD);

  typedef logic [CNT_W-1:0] cnt_t;

  clkMode_e modeQ;
  cnt_t     divCnt;
  cnt_t     lastCnt;
  cnt_t     halfLast;
  int       periodInt;
  logic     isMaster;

  always_comb begin
    case (modeQ)
      MODE_M512: periodInt = RATIO_HI  / BITS_PER_FRAME;
      MODE_M384: periodInt = RATIO_MID / BITS_PER_FRAME;
      MODE_M256: periodInt = RATIO_LO  / BITS_PER_FRAME;
      default:   periodInt = RATIO_LO  / BITS_PER_FRAME;
    endcase
    lastCnt  = cnt_t'(periodInt - 1);
    halfLast = cnt_t'(periodInt / 2 - 1);
    isMaster = (modeQ != MODE_EXT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ  <= clkMode_e'(modeSel);
      divCnt <= '0;
    end else if (isMaster) begin
      if (divCnt == lastCnt) divCnt <= '0;
      else                   divCnt <= divCnt + cnt_t'(1);
    end
  end

  always_comb begin
    stb.active  = isMaster;
    stb.wrap    = isMaster && (divCnt == lastCnt);
    stb.halfHit = isMaster && (divCnt == halfLast);
  end

endmodule

// File: rtl/aud_clk_dp.sv
module aud_clk_dp
  import aud_clk_pkg::*;
#(
  parameter int BITS_PER_FRAME = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  divStb_t  stb,
  output logic     bitClk,
  output logic     bitClkOe,
  output logic     frameClk,
  output logic     frameClkOe,
  output logic     extClk,
  output logic     en128,
  output logic     en64,
  output logic     bitFallStb
);

  localparam int IDX_W = $clog2(BITS_PER_FRAME);

  logic             bitClkQ;
  logic [IDX_W-1:0] bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitClkQ <= 1'b0;
      bitIdx  <= '0;
    end else if (stb.wrap) begin
      bitClkQ <= 1'b0;
      bitIdx  <= bitIdx + IDX_W'(1);
    end else if (stb.halfHit) begin
      bitClkQ <= 1'b1;
    end
  end

  always_comb begin
    bitClk     = bitClkQ;
    frameClk   = bitIdx[IDX_W-1];
    bitClkOe   = stb.active;
    frameClkOe = stb.active;
    extClk     = !stb.active;
    en128      = stb.halfHit || stb.wrap;
    en64       = stb.wrap;
    bitFallStb = stb.wrap;
  end

endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
  import aud_clk_pkg::*;
#(
  parameter int BITS_PER_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  output logic       bitClk,
  output logic       bitClkOe,
  output logic       frameClk,
  output logic       frameClkOe,
  output logic       extClk,
  output logic       en128,
  output logic       en64,
  output logic       bitFallStb
);

  divStb_t divStb;

  aud_clk_ctrl #(.BITS_PER_FRAME(BITS_PER_FRAME)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modeSel (modeSel),
    .stb     (divStb)
  );

  aud_clk_dp #(.BITS_PER_FRAME(BITS_PER_FRAME)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (divStb),
    .bitClk     (bitClk),
    .bitClkOe   (bitClkOe),
    .frameClk   (frameClk),
    .frameClkOe (frameClkOe),
    .extClk     (extClk),
    .en128      (en128),
    .en64       (en64),
    .bitFallStb (bitFallStb)
  );

endmodule

// File: rtl/aud_clk_chk.sv
module aud_clk_chk (
  input logic clk,
  input logic rst,
  input logic bitClk,
  input logic bitClkOe,
  input logic frameClk,
  input logic frameClkOe,
  input logic extClk,
  input logic en128,
  input logic en64,
  input logic bitFallStb
);

  AST_FALL_NEXT: assert property (@(posedge clk) disable iff (rst)
    bitFallStb |=> $fell(bitClk)); // R6

  AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(frameClk) |-> $fell(bitClk)); // R3

  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
    extClk |-> (!bitClkOe && !frameClkOe && !en128 && !en64 && !bitClk)); // R7

  AST_EN64_IN_EN128: assert property (@(posedge clk) disable iff (rst)
    en64 |-> en128); // R5

  AST_EN128_SINGLE: assert property (@(posedge clk) disable iff (rst)
    en128 |=> !en128); // R4

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(bitClkOe) && $stable(extClk))); // R8

endmodule

bind audio_clk_master aud_clk_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .bitClk     (bitClk),
  .bitClkOe   (bitClkOe),
  .frameClk   (frameClk),
  .frameClkOe (frameClkOe),
  .extClk     (extClk),
  .en128      (en128),
  .en64       (en64),
  .bitFallStb (bitFallStb)
);

// File: tb/test_audio_clk_master.sv
module test_audio_clk_master;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic bitClk, bitClkOe, frameClk, frameClkOe, extClk, en128, en64, bitFallStb;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  audio_clk_master i_audio_clk_master (
    .clk        (clk),
    .rst        (rst),
    .modeSel    (modeSel),
    .bitClk     (bitClk),
    .bitClkOe   (bitClkOe),
    .frameClk   (frameClk),
    .frameClkOe (frameClkOe),
    .extClk     (extClk),
    .en128      (en128),
    .en64       (en64),
    .bitFallStb (bitFallStb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not end, actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp, input int k);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s at k=%0d: actual=%b expected=%b", req, what, k, act, exp);
    end
  endtask

  task automatic applyReset(input logic [1:0] mode);
    @(negedge clk);
    rst = 1'b1;
    modeSel = mode;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Master run: reset into mode, then compare every cycle against cycle count k.
  task automatic runMaster(input logic [1:0] mode, input int period, input int cycles,
                           input int changeAt, input logic [1:0] otherMode, input string tag);
    applyReset(mode);
    // R9 reset state at k=0
    chk("R9", "bitClk reset", bitClk, 1'b0, 0);
    chk("R9", "frameClk reset", frameClk, 1'b0, 0);
    chk("R1", "bitClkOe", bitClkOe, 1'b1, 0);
    chk("R1", "frameClkOe", frameClkOe, 1'b1, 0);
    chk("R1", "extClk", extClk, 1'b0, 0);
    for (int k = 1; k <= cycles; k++) begin
      int c;
      logic eBc, eFr, e128, e64;
      @(posedge clk);
      @(negedge clk);
      if (k == changeAt) modeSel = otherMode;
      c    = k % period;
      eBc  = (c >= period / 2);
      eFr  = (((k / period) % 64) >= 32);
      e128 = (c == period / 2 - 1) || (c == period - 1);
      e64  = (c == period - 1);
      chk((k > changeAt && changeAt > 0) ? "R8" : "R2", {tag, " bitClk"}, bitClk, eBc, k);
      chk((k > changeAt && changeAt > 0) ? "R8" : "R3", {tag, " frameClk"}, frameClk, eFr, k);
      chk("R4", {tag, " en128"}, en128, e128, k);
      chk("R5", {tag, " en64"}, en64, e64, k);
      chk("R6", {tag, " bitFallStb"}, bitFallStb, e64, k);
      if (k % 97 == 0) chk("R1", {tag, " bitClkOe"}, bitClkOe, 1'b1, k);
    end
  endtask

  task automatic runExternal(input int cycles);
    applyReset(2'b00);
    for (int k = 0; k <= cycles; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (k == 50) modeSel = 2'b11; // R8 change without reset ignored
      chk("R7", "bitClkOe", bitClkOe, 1'b0, k);
      chk("R7", "frameClkOe", frameClkOe, 1'b0, k);
      chk("R7", "extClk", extClk, 1'b1, k);
      chk("R7", "bitClk", bitClk, 1'b0, k);
      chk("R7", "frameClk", frameClk, 1'b0, k);
      chk("R7", "en128", en128, 1'b0, k);
      chk("R7", "en64", en64, 1'b0, k);
      chk("R7", "bitFallStb", bitFallStb, 1'b0, k);
    end
  endtask

  initial begin
    runExternal(200);
    runMaster(2'b11, 4, 1100, 0, 2'b11, "m256");
    runMaster(2'b10, 6, 1700, 0, 2'b10, "m384");
    runMaster(2'b01, 8, 1300, 0, 2'b01, "m512");
    // R9: reset taken mid-frame, restart in a new mode
    runMaster(2'b11, 4, 300, 0, 2'b11, "m256b");
    runMaster(2'b10, 6, 500, 0, 2'b10, "m384b");
    // R8: live mode change without reset must be ignored
    runMaster(2'b11, 4, 600, 101, 2'b01, "m256chg");
    runMaster(2'b01, 8, 600, 77, 2'b00, "m512chg");
    runExternal(60);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule